// File: doc/BRIEF.md
# Redundant Comparator Decision Monitor

This block compares two one-bit decision streams that should agree: one from the sampling path under test and one from a simpler, trusted replica of that path. Each stream has its own valid strobe. Two strobes whose arrival cycles lie no more than `TOL` cycles apart form a pair. When a pair carries the same value, the primary decision is passed on. A pair that disagrees in value, and any strobe left without a partner, counts as an error. On an error the trusted reference decision is forwarded in place of the primary one.

The forwarded decision, its valid flag and its error flag come out of registers, one cycle after the cycle that settles the outcome, so the error flag always describes the decision beside it. Two further outputs tell the user that something went wrong: a sticky alarm, and a saturating count of error events. A synchronous clear input resets both. A waiting strobe is held in a one-deep slot for each stream, together with the number of cycles it has waited.

Top module: `redundant_cmp_monitor`

## Requirements
- R1: While and after reset, `out_vld_o`, `out_dec_o`, `out_err_o` and `alarm_o` read 0 and `err_cnt_o` reads 0 until the first event.
- R2: If both strobes arrive in the same cycle with equal values and neither stream has a waiting strobe, the next cycle shows `out_vld_o`=1, `out_err_o`=0 and `out_dec_o` equal to the primary value.
- R3: If both strobes arrive in the same cycle with different values, the next cycle shows `out_vld_o`=1, `out_err_o`=1 and `out_dec_o` equal to the reference value.
- R4: A strobe on either stream that is followed by a strobe on the other stream 1 to `TOL` cycles later is paired with it, in either order. The result appears one cycle after the second strobe, with the error flag set only if the two values differ.
- R5: A waiting strobe that gets no partner by `TOL` cycles after its arrival is a timing error. It yields `out_vld_o`=1 and `out_err_o`=1 in cycle arrival+`TOL`+1. `out_dec_o` carries the reference value if the lone strobe was a reference strobe, and 0 if it was a primary strobe.
- R6: A new strobe on a stream that already has a waiting strobe does two things. If the other stream strobes in the same cycle, the older waiting strobe is paired with that partner. Otherwise the older strobe is flushed as a timing error. In both cases the new strobe becomes the waiting one. At most one result is produced per cycle.
- R7: `alarm_o` becomes 1 in the same cycle as the first result with `out_err_o`=1, and stays 1 until `clr_i` is sampled high or reset is applied.
- R8: `err_cnt_o` increases by one with each result that has `out_err_o`=1 and holds at all ones instead of wrapping. `clr_i` sampled high sets it to 0 and wins over an error decided in the same cycle; that error sets neither the count nor the alarm.
- R9: `out_err_o` is never 1 unless `out_vld_o` is 1, and `out_vld_o` is a one-cycle pulse for each result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of alarm and error count |
| pri_vld_i | input | 1 | Strobe for the decision of the path under test |
| pri_dec_i | input | 1 | Decision of the path under test |
| ref_vld_i | input | 1 | Strobe for the decision of the trusted replica |
| ref_dec_i | input | 1 | Decision of the trusted replica |
| out_vld_o | output | 1 | Forwarded decision is valid |
| out_dec_o | output | 1 | Forwarded decision |
| out_err_o | output | 1 | Value or timing mismatch for this decision |
| alarm_o | output | 1 | Sticky error indication |
| err_cnt_o | output | CNT_W | Saturating error event count |

## Verification
The bench goes after strobe skew at exactly `TOL` cycles and at `TOL`+1. A window that is off by one cycle would either flag good pairs or let late partners pair silently. It also repeats strobes on a stream that is still waiting, including the case where the partner arrives in that same cycle; a design that pairs the newest strobe first would shift every later pairing by one. A lone primary strobe must fail over to 0 and a lone reference strobe to its own value, so swapping the fail-over source shows up as a wrong bit. Finally, the count is driven past all ones and cleared in the same cycle as an error, which catches wrap-around and a wrong priority between clear and error.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  // One settled outcome: a pair or a lone strobe.
  typedef struct packed {
    logic vld;
    logic dec;
    logic err;
  } rcm_evt_t;

endpackage

// File: rtl/rcm_slot.sv
module rcm_slot #(
  parameter int TOL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic own_vld,
  input  logic own_dec,
  input  logic peer_vld,
  input  logic peer_pend,
  output logic pend,
  output logic dec,
  output logic match,
  output logic expire
);

  localparam int AW = (TOL < 1) ? 1 : $clog2(TOL + 1);
  localparam logic [AW-1:0] TOL_C = AW'(TOL);
  localparam logic [AW-1:0] ONE_C = AW'(1);

  logic [AW-1:0] age_q, age_d;
  logic          pend_q, pend_d;
  logic          dec_q;
  logic          load;
  logic          age_en;

  // Next-state logic
  always_comb begin
    match  = pend_q & peer_vld;
    expire = pend_q & ~peer_vld & (own_vld | (age_q >= TOL_C));
    if (pend_q) begin
      load   = (match | expire) & own_vld;
      pend_d = (match | expire) ? own_vld : 1'b1;
    end else begin
      load   = own_vld & ~peer_vld & ~peer_pend;
      pend_d = load;
    end
    if (load)
      age_d = ONE_C;
    else if (pend_d && (age_q < TOL_C))
      age_d = age_q + ONE_C;
    else if (!pend_d)
      age_d = '0;
    else
      age_d = age_q;
    age_en = load | (pend_q != pend_d) | (pend_d & (age_q < TOL_C));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dec_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load)   dec_q <= own_dec;
      if (age_en) age_q <= age_d;
    end
  end

  assign pend = pend_q;
  assign dec  = dec_q;

  initial begin
    if (TOL < 1) $error("rcm_slot: TOL must be at least 1");
  end

  AST_AGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (age_q != '0 && age_q <= TOL_C)); // R5

  AST_LONE_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !peer_vld && age_q == TOL_C) |-> expire); // R5

endmodule

// File: rtl/rcm_out_stage.sv
module rcm_out_stage
  import rcm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rcm_evt_t evt,
  output logic     out_vld,
  output logic     out_dec,
  output logic     out_err
);

  logic vld_q, dec_q, err_q;
  logic dec_en;

  always_comb begin
    dec_en = evt.vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dec_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= evt.vld;
      err_q <= evt.vld & evt.err;
      if (dec_en) dec_q <= evt.dec;
    end
  end

  assign out_vld = vld_q;
  assign out_dec = dec_q;
  assign out_err = err_q;

  AST_ERR_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_vld); // R9

  AST_VLD_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt.vld |=> (out_vld && out_dec == $past(evt.dec))); // R9

endmodule

// File: rtl/rcm_tally.sv
module rcm_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic             alarm,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

  logic             alarm_q, alarm_d, alarm_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    alarm_en = clr | hit;
    alarm_d  = ~clr;
    cnt_en   = clr | (hit & (cnt_q != MAX_C));
    cnt_d    = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (alarm_en) alarm_q <= alarm_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  assign alarm = alarm_q;
  assign cnt   = cnt_q;

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !clr) |=> alarm_q); // R7

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !alarm_q)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == MAX_C) |=> cnt_q == MAX_C); // R8

endmodule

// File: rtl/redundant_cmp_monitor.sv
module redundant_cmp_monitor
  import rcm_pkg::*;
#(
  parameter int TOL   = 1,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pri_vld_i,
  input  logic             pri_dec_i,
  input  logic             ref_vld_i,
  input  logic             ref_dec_i,
  output logic             out_vld_o,
  output logic             out_dec_o,
  output logic             out_err_o,
  output logic             alarm_o,
  output logic [CNT_W-1:0] err_cnt_o
);

  logic     p_pend, p_dec, p_match, p_expire;
  logic     r_pend, r_dec, r_match, r_expire;
  logic     pair_ev, a_dec, b_dec, differ;
  rcm_evt_t evt;

  rcm_slot #(.TOL(TOL)) u_pri (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_vld  (pri_vld_i),
    .own_dec  (pri_dec_i),
    .peer_vld (ref_vld_i),
    .peer_pend(r_pend),
    .pend     (p_pend),
    .dec      (p_dec),
    .match    (p_match),
    .expire   (p_expire)
  );

  rcm_slot #(.TOL(TOL)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_vld  (ref_vld_i),
    .own_dec  (ref_dec_i),
    .peer_vld (pri_vld_i),
    .peer_pend(p_pend),
    .pend     (r_pend),
    .dec      (r_dec),
    .match    (r_match),
    .expire   (r_expire)
  );

  // Decision: pair the oldest strobes, or report a lone one.
  always_comb begin
    pair_ev = p_match | r_match | (~p_pend & ~r_pend & pri_vld_i & ref_vld_i);
    a_dec   = p_pend ? p_dec : pri_dec_i;
    b_dec   = r_pend ? r_dec : ref_dec_i;
    differ  = a_dec ^ b_dec;
    evt.vld = pair_ev | p_expire | r_expire;
    if (p_expire) begin
      evt.err = 1'b1;
      evt.dec = 1'b0;
    end else if (r_expire) begin
      evt.err = 1'b1;
      evt.dec = r_dec;
    end else begin
      evt.err = pair_ev & differ;
      evt.dec = differ ? b_dec : a_dec;
    end
  end

  rcm_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .out_vld(out_vld_o),
    .out_dec(out_dec_o),
    .out_err(out_err_o)
  );

  rcm_tally #(.CNT_W(CNT_W)) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_i),
    .hit  (evt.vld & evt.err),
    .alarm(alarm_o),
    .cnt  (err_cnt_o)
  );

  AST_ONE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_pend && r_pend)); // R6

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pair_ev, p_expire, r_expire}) <= 1); // R6

  AST_AGREE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_vld_i && ref_vld_i && !p_pend && !r_pend && pri_dec_i == ref_dec_i)
    |=> (out_vld_o && !out_err_o && out_dec_o == $past(pri_dec_i))); // R2

  AST_DIFFER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_vld_i && ref_vld_i && !p_pend && !r_pend && pri_dec_i != ref_dec_i)
    |=> (out_vld_o && out_err_o && out_dec_o == $past(ref_dec_i))); // R3

  AST_ALARM_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.vld && evt.err && !clr_i) |=> (alarm_o && out_err_o)); // R7

endmodule

// File: tb/sim_redundant_cmp_monitor.sv
module sim_redundant_cmp_monitor;

  localparam int TOL   = 1;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic pri_vld_i = 1'b0, pri_dec_i = 1'b0, ref_vld_i = 1'b0, ref_dec_i = 1'b0;
  logic out_vld_o, out_dec_o, out_err_o, alarm_o;
  logic [CNT_W-1:0] err_cnt_o;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    run = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // Reference model state
  bit m_p_pend, m_p_dec, m_r_pend, m_r_dec;
  int m_p_t, m_r_t;
  bit e_vld, e_dec, e_err, e_alarm;
  int e_cnt;

  always #2 clk = ~clk;

  redundant_cmp_monitor #(.TOL(TOL), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .pri_vld_i(pri_vld_i), .pri_dec_i(pri_dec_i),
    .ref_vld_i(ref_vld_i), .ref_dec_i(ref_dec_i),
    .out_vld_o(out_vld_o), .out_dec_o(out_dec_o), .out_err_o(out_err_o),
    .alarm_o(alarm_o), .err_cnt_o(err_cnt_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p_pend = 0; m_r_pend = 0; m_p_dec = 0; m_r_dec = 0;
      m_p_t = 0; m_r_t = 0;
      e_vld = 0; e_dec = 0; e_err = 0; e_alarm = 0; e_cnt = 0;
    end else begin
      bit ev, er, dv;
      ev = 0; er = 0; dv = 0;
      if (m_p_pend) begin
        if (ref_vld_i) begin
          ev = 1; er = (m_p_dec != ref_dec_i); dv = er ? ref_dec_i : m_p_dec;
          m_p_pend = pri_vld_i; m_p_dec = pri_dec_i; m_p_t = cyc;
        end else if (pri_vld_i || (cyc - m_p_t >= TOL)) begin
          ev = 1; er = 1; dv = 0;
          m_p_pend = pri_vld_i; m_p_dec = pri_dec_i; m_p_t = cyc;
        end
      end else if (m_r_pend) begin
        if (pri_vld_i) begin
          ev = 1; er = (pri_dec_i != m_r_dec); dv = er ? m_r_dec : pri_dec_i;
          m_r_pend = ref_vld_i; m_r_dec = ref_dec_i; m_r_t = cyc;
        end else if (ref_vld_i || (cyc - m_r_t >= TOL)) begin
          ev = 1; er = 1; dv = m_r_dec;
          m_r_pend = ref_vld_i; m_r_dec = ref_dec_i; m_r_t = cyc;
        end
      end else if (pri_vld_i && ref_vld_i) begin
        ev = 1; er = (pri_dec_i != ref_dec_i); dv = ref_dec_i;
      end else if (pri_vld_i) begin
        m_p_pend = 1; m_p_dec = pri_dec_i; m_p_t = cyc;
      end else if (ref_vld_i) begin
        m_r_pend = 1; m_r_dec = ref_dec_i; m_r_t = cyc;
      end
      e_vld = ev;
      e_err = ev && er;
      if (ev) e_dec = dv;
      if (clr_i) begin
        e_alarm = 0; e_cnt = 0;
      end else if (ev && er) begin
        e_alarm = 1;
        if (e_cnt < CMAX) e_cnt = e_cnt + 1;
      end
      cyc = cyc + 1;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (run && !finished) begin
      n_chk++;
      if (out_vld_o !== e_vld || out_err_o !== e_err || alarm_o !== e_alarm ||
          int'(err_cnt_o) != e_cnt || (e_vld && out_dec_o !== e_dec)) begin
        n_err++;
        $display("FAIL %s cyc=%0d actual vld=%b dec=%b err=%b alarm=%b cnt=%0d expected vld=%b dec=%b err=%b alarm=%b cnt=%0d",
                 cur_req, cyc, out_vld_o, out_dec_o, out_err_o, alarm_o, err_cnt_o,
                 e_vld, e_dec, e_err, e_alarm, e_cnt);
      end
    end
  end

  task automatic step(input bit pv, input bit pb, input bit rv, input bit rb, input bit c);
    @(negedge clk);
    pri_vld_i = pv; pri_dec_i = pb; ref_vld_i = rv; ref_dec_i = rb; clr_i = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic check_now(input string req, input bit cond, input int act, input int exp);
    @(negedge clk);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at rest during reset
    n_chk++;
    if (out_vld_o !== 0 || out_err_o !== 0 || alarm_o !== 0 || err_cnt_o !== 0) begin
      n_err++;
      $display("FAIL R1 actual vld=%b err=%b alarm=%b cnt=%0d expected all 0",
               out_vld_o, out_err_o, alarm_o, err_cnt_o);
    end
    rst_n = 1'b1;
    run = 1;
    cur_req = "R1"; idle(3);

    cur_req = "R2"; step(1, 1, 1, 1, 0); step(1, 0, 1, 0, 0); idle(2);
    cur_req = "R3"; step(1, 1, 1, 0, 0); step(1, 0, 1, 1, 0); idle(2);

    cur_req = "R4";
    step(1, 1, 0, 0, 0); step(0, 0, 1, 1, 0); idle(2);
    step(0, 0, 1, 0, 0); step(1, 1, 0, 0, 0); idle(2);
    step(0, 0, 1, 1, 0); step(1, 0, 0, 0, 0); idle(2);

    cur_req = "R5";
    step(1, 1, 0, 0, 0); idle(4);
    step(0, 0, 1, 1, 0); idle(4);
    step(1, 1, 0, 0, 0); idle(1); step(0, 0, 1, 1, 0); idle(3);

    cur_req = "R6";
    step(1, 1, 0, 0, 0); step(1, 0, 0, 0, 0); step(0, 0, 1, 0, 0); idle(2);
    step(1, 1, 0, 0, 0); step(1, 0, 1, 1, 0); step(0, 0, 1, 0, 0); idle(2);
    step(0, 0, 1, 1, 0); step(1, 1, 1, 0, 0); step(1, 0, 0, 0, 0); idle(2);

    cur_req = "R7";
    step(0, 0, 0, 0, 1); idle(2);
    step(1, 0, 1, 1, 0); idle(5);
    check_now("R7", alarm_o === 1'b1, int'(alarm_o), 1);

    cur_req = "R8";
    step(0, 0, 0, 0, 1); idle(1);
    step(1, 1, 1, 0, 1); idle(2);
    check_now("R8", err_cnt_o === '0 && alarm_o === 1'b0, int'(err_cnt_o), 0);
    for (int i = 0; i < CMAX + 15; i++) step(1, i[0], 1, ~i[0], 0);
    idle(2);
    check_now("R8", int'(err_cnt_o) == CMAX, int'(err_cnt_o), CMAX);
    step(0, 0, 0, 0, 1); idle(2);

    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 45, $urandom_range(0, 1) == 1, (r % 3) != 0 && r < 70,
           $urandom_range(0, 1) == 1, r == 97);
    end
    idle(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule